// File: doc/BRIEF.md
# Queue Almost-Full Status Bus Scanner

This block puts the almost-full flags of 128 queues onto a 32-bit status bus, one status word at a time. Each word carries the flags of 32 consecutive queues, so one device has four words. The flags themselves come in from outside as a flat vector. The block only chooses which word is shown and when it is shown.

The operating mode is taken from a pin while master reset is held. In polled mode the device that holds a token walks through its four words, one per clock. It raises a sync output while its first word is on the bus, and raises a token-out pulse while its last word is on the bus. Token-out goes to the token-in of the next device, and the last device feeds the first. A lone device loops its own token-out back to its own token-in. In direct mode an external strobe, together with an address, picks the word to show. The strobe is honoured only after configuration has finished, and only when the device field of the address matches this device's ID.

Top module: `flag_scan_bus`

## Requirements
- R1: The mode pin is sampled only on clock edges where reset is high: 1 selects polled mode and 0 selects direct mode. Changes on the pin outside reset have no effect.
- R2: Word w carries queues 32w to 32w+31, with bit i of the bus being the flag of queue 32w+i. While the bus is enabled it follows the live flag inputs of the selected word. While the bus is disabled it reads zero.
- R3: In polled mode a token holder shows word 0 on its first loading edge, then words 1, 2 and 3 on the next three edges, with the bus enabled throughout.
- R4: Sync is high exactly while this device has word 0 on the bus in polled mode. It is never high in direct mode.
- R5: Token-out is high during the cycle in which word 3 is shown, and only in polled mode. An edge that sees token-in high while the device is not part-way through its scan loads word 0. In a single looped device, word 0 therefore returns on the fifth edge.
- R6: After reset in polled mode, a device with ID 0 loads word 0 on the first edge. Any other ID keeps the bus disabled until a token arrives.
- R7: After showing word 3 with no token arriving, a polled device disables the bus on the next edge and stays idle.
- R8: In direct mode, an edge with strobe and programming-done both high takes the address, where bits [9:7] are the device field and bits [6:0] are the queue. On an ID match it enables the bus with word = queue/32. On a mismatch it disables the bus. Without the strobe, the selection holds.
- R9: While programming-done is low, a direct-mode strobe changes neither the bus enable nor the selected word.
- R10: During and just after reset, the bus enable, sync and token-out are low and the bus reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high master reset |
| mode_pin_i | input | 1 | Mode select, sampled during reset (1 polled, 0 direct) |
| dev_id_i | input | 3 | Device ID, sampled during reset |
| prog_done_i | input | 1 | High once configuration has finished |
| strobe_i | input | 1 | Direct-mode word select strobe |
| wr_addr_i | input | 10 | Device field [9:7] and queue number [6:0] |
| q_almost_full_i | input | 128 | Per-queue almost-full flags |
| tok_in_i | input | 1 | Token from the previous device in the ring |
| flag_bus_o | output | 32 | Selected status word |
| bus_oe_o | output | 1 | High while this device drives the status bus |
| sync_o | output | 1 | Marks word 0 of this device in polled mode |
| tok_out_o | output | 1 | Token pulse while word 3 is shown |

## Verification
A wrong scan index shows up on the very next clock as the wrong 32-bit pattern on the bus. The same fault also misplaces the sync or token pulse. A lost token or a stuck owner state shows up within four clocks, as a bus enable that never rises or never falls. A mis-decoded direct selection appears one edge after the strobe, as a wrong word or a wrong enable. The bench places a distinct pattern in each word, so that any of these faults is visible at the ports.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_POLLED = 1'b1
    } bus_mode_e;

    function automatic int unsigned words_per_dev(int unsigned n_queues, int unsigned word_w);
        return n_queues / word_w;
    endfunction

endpackage

// File: rtl/fsb_cfg_latch.sv
module fsb_cfg_latch #(
    parameter int ID_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_pin_i,
    input  logic [ID_W-1:0]     id_i,
    output fsb_pkg::bus_mode_e  mode_o,
    output logic [ID_W-1:0]     id_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o <= mode_pin_i ? fsb_pkg::MODE_POLLED : fsb_pkg::MODE_DIRECT;
            id_o   <= id_i;
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_o)); // R1
endmodule

// File: rtl/fsb_poll_seq.sv
module fsb_poll_seq #(
    parameter int N_WORDS = 4,
    localparam int WIDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              first_owner_i,
    input  logic              tok_in_i,
    output logic              drive_o,
    output logic [WIDX_W-1:0] widx_o,
    output logic              tok_out_o
);
    localparam logic [WIDX_W-1:0] LAST = WIDX_W'(N_WORDS - 1);

    logic armed;
    logic mid_scan;

    assign mid_scan  = drive_o && (widx_o != LAST);
    assign tok_out_o = enable_i && drive_o && (widx_o == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_o <= 1'b0;
            widx_o  <= '0;
            armed   <= first_owner_i;
        end else if (enable_i) begin
            if (mid_scan) begin
                widx_o <= widx_o + 1'b1;
            end else if (armed || tok_in_i) begin
                drive_o <= 1'b1;
                widx_o  <= '0;
                armed   <= 1'b0;
            end else begin
                drive_o <= 1'b0;
            end
        end
    end

    AST_SCAN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (enable_i && drive_o && widx_o != LAST) |=> (drive_o && widx_o == $past(widx_o) + 1'b1)); // R3
    AST_TOKEN_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (enable_i && tok_in_i && !(drive_o && widx_o != LAST)) |=> (drive_o && widx_o == '0)); // R5
    AST_RELEASE_BUS: assert property (@(posedge clk) disable iff (rst)
        (enable_i && drive_o && widx_o == LAST && !tok_in_i) |=> !drive_o); // R7
endmodule

// File: rtl/fsb_direct_sel.sv
module fsb_direct_sel #(
    parameter int ID_W    = 3,
    parameter int QADDR_W = 7,
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 4,
    localparam int WIDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int ADDR_W = ID_W + QADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              prog_done_i,
    input  logic              strobe_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ID_W-1:0]   id_i,
    output logic              drive_o,
    output logic [WIDX_W-1:0] widx_o
);
    logic [ID_W-1:0]    dev_field;
    logic [QADDR_W-1:0] q_field;
    logic               take;

    assign dev_field = addr_i[ADDR_W-1:QADDR_W];
    assign q_field   = addr_i[QADDR_W-1:0];
    assign take      = enable_i && strobe_i && prog_done_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_o <= 1'b0;
            widx_o  <= '0;
        end else if (take) begin
            drive_o <= (dev_field == id_i);
            widx_o  <= WIDX_W'(q_field / QADDR_W'(WORD_W));
        end
    end

    AST_NO_SEL_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
        (!prog_done_i || !strobe_i) |=> ($stable(drive_o) && $stable(widx_o))); // R9
    AST_ID_MISMATCH_OFF: assert property (@(posedge clk) disable iff (rst)
        (enable_i && strobe_i && prog_done_i && addr_i[ADDR_W-1:QADDR_W] != id_i) |=> !drive_o); // R8
endmodule

// File: rtl/fsb_word_mux.sv
module fsb_word_mux #(
    parameter int N_WORDS = 4,
    parameter int WORD_W  = 32,
    localparam int WIDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic [N_WORDS*WORD_W-1:0] flags_i,
    input  logic                      drive_i,
    input  logic [WIDX_W-1:0]         widx_i,
    output logic [WORD_W-1:0]         bus_o
);
    logic [WORD_W-1:0] words [N_WORDS];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_split
        assign words[g] = flags_i[g*WORD_W +: WORD_W];
    end

    assign bus_o = drive_i ? words[widx_i] : '0;
endmodule

// File: rtl/flag_scan_bus.sv
module flag_scan_bus #(
    parameter int N_QUEUES = 128,
    parameter int WORD_W   = 32,
    parameter int ID_W     = 3,
    localparam int N_WORDS = int'(fsb_pkg::words_per_dev(N_QUEUES, WORD_W)),
    localparam int WIDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int QADDR_W = $clog2(N_QUEUES),
    localparam int ADDR_W  = ID_W + QADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_pin_i,
    input  logic [ID_W-1:0]     dev_id_i,
    input  logic                prog_done_i,
    input  logic                strobe_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [N_QUEUES-1:0] q_almost_full_i,
    input  logic                tok_in_i,
    output logic [WORD_W-1:0]   flag_bus_o,
    output logic                bus_oe_o,
    output logic                sync_o,
    output logic                tok_out_o
);
    fsb_pkg::bus_mode_e mode;
    logic [ID_W-1:0]    id_q;
    logic               polled;
    logic               p_drive, d_drive, p_tok;
    logic [WIDX_W-1:0]  p_widx, d_widx, sel_widx;

    fsb_cfg_latch #(.ID_W(ID_W)) i_cfg (
        .clk(clk), .rst(rst), .mode_pin_i(mode_pin_i), .id_i(dev_id_i),
        .mode_o(mode), .id_o(id_q)
    );

    assign polled = (mode == fsb_pkg::MODE_POLLED);

    fsb_poll_seq #(.N_WORDS(N_WORDS)) i_poll (
        .clk(clk), .rst(rst), .enable_i(polled),
        .first_owner_i(dev_id_i == '0), .tok_in_i(tok_in_i),
        .drive_o(p_drive), .widx_o(p_widx), .tok_out_o(p_tok)
    );

    fsb_direct_sel #(.ID_W(ID_W), .QADDR_W(QADDR_W), .WORD_W(WORD_W), .N_WORDS(N_WORDS)) i_direct (
        .clk(clk), .rst(rst), .enable_i(!polled), .prog_done_i(prog_done_i),
        .strobe_i(strobe_i), .addr_i(wr_addr_i), .id_i(id_q),
        .drive_o(d_drive), .widx_o(d_widx)
    );

    assign bus_oe_o  = polled ? p_drive : d_drive;
    assign sel_widx  = polled ? p_widx  : d_widx;
    assign sync_o    = polled && p_drive && (p_widx == '0);
    assign tok_out_o = p_tok;

    fsb_word_mux #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) i_mux (
        .flags_i(q_almost_full_i), .drive_i(bus_oe_o), .widx_i(sel_widx),
        .bus_o(flag_bus_o)
    );

    AST_SYNC_ON_FIRST: assert property (@(posedge clk) disable iff (rst)
        sync_o |-> (bus_oe_o && flag_bus_o == q_almost_full_i[WORD_W-1:0])); // R4
    AST_DIRECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !polled |-> (!sync_o && !tok_out_o)); // R4
    AST_BUS_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_o |-> (flag_bus_o == '0)); // R2
endmodule

// File: tb/test_flag_scan_bus.sv
module test_flag_scan_bus;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_pin = 1'b1;
    logic [2:0]   dev_id = 3'd0;
    logic         prog_done = 1'b0;
    logic         strobe = 1'b0;
    logic [9:0]   wr_addr = '0;
    logic [127:0] flags;
    logic         loop_en = 1'b1;
    logic         ext_tok = 1'b0;
    logic         tok_in;
    logic [31:0]  bus;
    logic         oe, sync, tok_out;
    int           n_tests = 0;
    int           n_fail = 0;

    always #5 clk = ~clk;

    assign tok_in = loop_en ? tok_out : ext_tok;

    flag_scan_bus i_flag_scan_bus (
        .clk(clk), .rst(rst), .mode_pin_i(mode_pin), .dev_id_i(dev_id),
        .prog_done_i(prog_done), .strobe_i(strobe), .wr_addr_i(wr_addr),
        .q_almost_full_i(flags), .tok_in_i(tok_in),
        .flag_bus_o(bus), .bus_oe_o(oe), .sync_o(sync), .tok_out_o(tok_out)
    );

    function automatic logic [31:0] pat(int w);
        return 32'h1111_1111 * (w + 1);
    endfunction

    // strobe, done, addr[9:0], exp_oe, exp_word[1:0]
    localparam logic [14:0] DVEC [8] = '{
        {1'b1, 1'b0, 10'd424, 1'b0, 2'd0},
        {1'b1, 1'b1, 10'd424, 1'b1, 2'd1},
        {1'b0, 1'b1, 10'd511, 1'b1, 2'd1},
        {1'b1, 1'b0, 10'd511, 1'b1, 2'd1},
        {1'b1, 1'b1, 10'd511, 1'b1, 2'd3},
        {1'b1, 1'b1, 10'd384, 1'b1, 2'd0},
        {1'b1, 1'b1, 10'd356, 1'b0, 2'd0},
        {1'b1, 1'b1, 10'd454, 1'b1, 2'd2}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(logic m, logic [2:0] id, logic lp);
        @(negedge clk);
        rst = 1'b1; mode_pin = m; dev_id = id; loop_en = lp;
        strobe = 1'b0; prog_done = 1'b0; ext_tok = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk_out(string req, logic e_oe, int w, logic e_sync, logic e_tok);
        chk({req, " oe"}, 32'(oe), 32'(e_oe));
        chk({req, " bus"}, bus, e_oe ? pat(w) : 32'h0);
        chk({req, " sync"}, 32'(sync), 32'(e_sync));
        chk({req, " tok_out"}, 32'(tok_out), 32'(e_tok));
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int w = 0; w < 4; w++) flags[w*32 +: 32] = pat(w);

        // Single polled device, ID 0, looped token
        do_reset(1'b1, 3'd0, 1'b1);
        #1;
        chk_out("R10 reset", 1'b0, 0, 1'b0, 1'b0);
        mode_pin = 1'b0; // R1: ignored outside reset
        for (int e = 1; e <= 9; e++) begin
            tick();
            chk_out("R3 R4 R5 R6 R1 polled scan", 1'b1, (e - 1) % 4, ((e - 1) % 4) == 0, ((e - 1) % 4) == 3);
        end
        // R2 live flags of shown word 0
        flags[31:0] = 32'hA5A5_5A5A;
        #1;
        chk("R2 live flags", bus, 32'hA5A5_5A5A);
        flags[31:0] = pat(0);

        // Polled device with ID 5, external token
        do_reset(1'b1, 3'd5, 1'b0);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk_out("R6 non-zero ID idle", 1'b0, 0, 1'b0, 1'b0);
        end
        @(negedge clk); ext_tok = 1'b1;
        tick();
        chk_out("R5 token load", 1'b1, 0, 1'b1, 1'b0);
        @(negedge clk); ext_tok = 1'b0;
        for (int w = 1; w < 4; w++) begin
            tick();
            chk_out("R3 R5 scan", 1'b1, w, 1'b0, w == 3);
        end
        tick();
        chk_out("R7 release", 1'b0, 0, 1'b0, 1'b0);
        tick();
        chk_out("R7 stay idle", 1'b0, 0, 1'b0, 1'b0);

        // Direct mode, ID 3
        do_reset(1'b0, 3'd3, 1'b0);
        #1;
        chk_out("R10 direct reset", 1'b0, 0, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            strobe = DVEC[i][14]; prog_done = DVEC[i][13]; wr_addr = DVEC[i][12:3];
            tick();
            chk_out("R8 R9 direct select", DVEC[i][2], int'(DVEC[i][1:0]), 1'b0, 1'b0);
        end
        @(negedge clk);
        strobe = 1'b0; mode_pin = 1'b1; ext_tok = 1'b1;
        tick();
        chk_out("R1 R4 direct hold", 1'b1, 2, 1'b0, 1'b0);
        ext_tok = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule